// File: doc/BRIEF.md
# System exception pending arbiter

This block keeps the pending state of six system exceptions and of one non-maskable exception. Every cycle it picks the most urgent exception that is pending and allowed to run. The six arbitrated exceptions carry the sparse numbers 4, 5, 6, 11, 14 and 15. The first three are configurable faults, and each of them has its own enable bit. Software or hardware marks an exception pending with a one-cycle set pulse and withdraws it with a clear pulse. The exception entry logic pulses `ack` to take the exception that the block is currently showing, and that removes its pending bit.

Each exception owns one byte-wide slot of the priority bus. Only the top three bits of the slot hold its priority, and a lower value is more urgent. When two values are equal, the lower exception number wins. A pending non-maskable exception beats everything else and is reported as number 2. When nothing can be selected, the output shows number 0 with the valid flag low. Both the selection and the pending bits are registered, so the outputs follow a pulse or a change of enable or priority at the next clock edge.

Top module: `sys_exc_arbiter`

## Requirements
- R1: After reset, `pend_out` and `nmi_pend` are 0, `sel_num` is 0 and `sel_valid` is 0.
- R2: A 1 on `pend_set[i]` at a clock edge makes `pend_out[i]` 1 after that edge. Bit i stands for exception number 4, 5, 6, 11, 14 or 15 for i = 0 to 5.
- R3: A 1 on `pend_clr[i]` alone makes `pend_out[i]` 0 after the edge. When set and clear arrive together, set wins.
- R4: `sel_num` shows the number of the pending, enabled exception with the lowest priority value. A tie goes to the lower exception number. `sel_valid` is 1 whenever such an exception exists.
- R5: Exceptions 4, 5 and 6 (bits 0 to 2) take part in selection only while `fault_en[i]` is 1. Exceptions 11, 14 and 15 are always enabled.
- R6: The priority of bit i is `prio_slots[8*i+7 : 8*i+5]`. Bits `8*i+4 : 8*i` have no effect on the selection.
- R7: While `nmi_pend` is 1, `sel_num` is 2 and `sel_valid` is 1, whatever the other inputs are. `nmi_set` makes `nmi_pend` 1 after the edge.
- R8: `ack` clears the pending bit of the exception shown on `sel_num` in that cycle. Showing 2 means the non-maskable bit is cleared. When `sel_valid` is 0, `ack` changes no pending bit. A set pulse in the same cycle wins over `ack`.
- R9: With no eligible exception pending, `sel_num` is 0 and `sel_valid` is 0.
- R10: A change of `fault_en` or `prio_slots` shows on `sel_num` after the next clock edge. A change of a pending bit shows on `sel_num` at the same edge as on `pend_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_set | input | 6 | Set-pending pulses, bit i for exception 4,5,6,11,14,15 |
| pend_clr | input | 6 | Clear-pending pulses, same bit order |
| nmi_set | input | 1 | Set-pending pulse for the non-maskable exception |
| fault_en | input | 3 | Enables for exceptions 4, 5, 6 |
| prio_slots | input | 48 | Byte slot per exception, priority in the top 3 bits |
| ack | input | 1 | Takes the currently shown exception, clearing its pending bit |
| pend_out | output | 6 | Pending bits |
| nmi_pend | output | 1 | Non-maskable pending bit |
| sel_num | output | 4 | Selected exception number, 0 when none |
| sel_valid | output | 1 | A selection is present |

## Verification
A wrong pending bit shows on `pend_out` one edge after the pulse that caused it. It also distorts `sel_num` at that same edge, so the bench can catch it in the cycle it occurs. A wrong comparison or a wrong tie rule only shows up for some combinations of pending bits, enables and priorities. For that reason the bench sweeps all 64 pending patterns, all 8 enable patterns and several priority sets, checking each result one edge after the stimulus. A broken `ack` path shows in one of two ways. A bit may stay pending after it was taken. Or the wrong bit may clear, which then repeats or skips a number in the next cycle of an acknowledge sequence.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
   localparam int NUM_EXC   = 6;
   localparam int EXC_NUM_W = 4;
   localparam logic [EXC_NUM_W-1:0] NMI_NUM = EXC_NUM_W'(2);

   // exception number carried by pending bit idx
   function automatic logic [EXC_NUM_W-1:0] exc_num(input int idx);
      case (idx)
         0: exc_num = EXC_NUM_W'(4);
         1: exc_num = EXC_NUM_W'(5);
         2: exc_num = EXC_NUM_W'(6);
         3: exc_num = EXC_NUM_W'(11);
         4: exc_num = EXC_NUM_W'(14);
         default: exc_num = EXC_NUM_W'(15);
      endcase
   endfunction
endpackage

// File: rtl/exc_pend_bank.sv
module exc_pend_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   input  logic [N-1:0] ack_oh_i,
   input  logic         nmi_set_i,
   input  logic         nmi_ack_i,
   output logic [N-1:0] pend_d_o,
   output logic [N-1:0] pend_q_o,
   output logic         nmi_d_o,
   output logic         nmi_q_o
);
   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_bit
         assign pend_d_o[g] = set_i[g] | (pend_q_o[g] & ~clr_i[g] & ~ack_oh_i[g]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q_o[g] <= 1'b0;
            else        pend_q_o[g] <= pend_d_o[g];
         end

         p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_q_o[g]);
         p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !pend_q_o[g]);
      end
   endgenerate

   assign nmi_d_o = nmi_set_i | (nmi_q_o & ~nmi_ack_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nmi_q_o <= 1'b0;
      else        nmi_q_o <= nmi_d_o;
   end

   p_nmi_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_set_i |=> nmi_q_o);
endmodule

// File: rtl/exc_prio_select.sv
module exc_prio_select
   import exc_arb_pkg::*;
#(
   parameter int N      = NUM_EXC,
   parameter int NF     = 3,
   parameter int PRIO_W = 3,
   parameter int SLOT_W = 8
) (
   input  logic [N-1:0]          pend_i,
   input  logic                  nmi_i,
   input  logic [NF-1:0]         en_i,
   input  logic [N*SLOT_W-1:0]   slots_i,
   output logic [N-1:0]          sel_oh_o,
   output logic                  sel_nmi_o,
   output logic [EXC_NUM_W-1:0]  sel_num_o,
   output logic                  sel_valid_o
);
   localparam int LOW_W = SLOT_W - PRIO_W;
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

   logic [PRIO_W-1:0] prio [N];
   logic [N-1:0]      elig;
   logic [N*LOW_W-1:0] unused_low;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_slot
         assign prio[g] = slots_i[g*SLOT_W+SLOT_W-1 -: PRIO_W];
         if (LOW_W > 0) begin : g_low
            assign unused_low[g*LOW_W +: LOW_W] = slots_i[g*SLOT_W +: LOW_W];
         end
         if (g < NF) begin : g_gated
            assign elig[g] = pend_i[g] & en_i[g];
         end else begin : g_always
            assign elig[g] = pend_i[g];
         end
      end
   endgenerate

   logic              found;
   logic [IDX_W-1:0]  best_idx;
   logic [PRIO_W-1:0] best_prio;

   // ascending scan with strict compare keeps the lower number on a tie
   always_comb begin
      found     = 1'b0;
      best_idx  = '0;
      best_prio = '1;
      for (int i = 0; i < N; i++) begin
         if (elig[i] && (!found || prio[i] < best_prio)) begin
            found     = 1'b1;
            best_idx  = IDX_W'(i);
            best_prio = prio[i];
         end
      end
   end

   always_comb begin
      sel_oh_o    = '0;
      sel_nmi_o   = nmi_i;
      sel_valid_o = nmi_i | found;
      sel_num_o   = '0;
      if (nmi_i) begin
         sel_num_o = NMI_NUM;
      end else if (found) begin
         sel_oh_o[best_idx] = 1'b1;
         sel_num_o          = exc_num(int'(best_idx));
      end
   end
endmodule

// File: rtl/sys_exc_arbiter.sv
module sys_exc_arbiter
   import exc_arb_pkg::*;
#(
   parameter int PRIO_W    = 3,
   parameter int SLOT_W    = 8,
   parameter int NUM_FAULT = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_EXC-1:0]      pend_set,
   input  logic [NUM_EXC-1:0]      pend_clr,
   input  logic                    nmi_set,
   input  logic [NUM_FAULT-1:0]    fault_en,
   input  logic [NUM_EXC*SLOT_W-1:0] prio_slots,
   input  logic                    ack,
   output logic [NUM_EXC-1:0]      pend_out,
   output logic                    nmi_pend,
   output logic [EXC_NUM_W-1:0]    sel_num,
   output logic                    sel_valid
);
   generate
      if (PRIO_W < 1 || PRIO_W > SLOT_W) begin : g_bad_prio
         $error("PRIO_W must lie between 1 and SLOT_W");
      end
      if (NUM_FAULT < 1 || NUM_FAULT > NUM_EXC) begin : g_bad_fault
         $error("NUM_FAULT must lie between 1 and NUM_EXC");
      end
   endgenerate

   logic [NUM_EXC-1:0]   pend_d, sel_oh_d, sel_oh_q, ack_oh;
   logic                 nmi_d, sel_nmi_d, sel_nmi_q, valid_d;
   logic [EXC_NUM_W-1:0] num_d;

   assign ack_oh = {NUM_EXC{ack}} & sel_oh_q;

   exc_pend_bank #(.N(NUM_EXC)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (pend_set),
      .clr_i     (pend_clr),
      .ack_oh_i  (ack_oh),
      .nmi_set_i (nmi_set),
      .nmi_ack_i (ack & sel_nmi_q),
      .pend_d_o  (pend_d),
      .pend_q_o  (pend_out),
      .nmi_d_o   (nmi_d),
      .nmi_q_o   (nmi_pend)
   );

   exc_prio_select #(
      .N(NUM_EXC), .NF(NUM_FAULT), .PRIO_W(PRIO_W), .SLOT_W(SLOT_W)
   ) u_sel (
      .pend_i      (pend_d),
      .nmi_i       (nmi_d),
      .en_i        (fault_en),
      .slots_i     (prio_slots),
      .sel_oh_o    (sel_oh_d),
      .sel_nmi_o   (sel_nmi_d),
      .sel_num_o   (num_d),
      .sel_valid_o (valid_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_oh_q  <= '0;
         sel_nmi_q <= 1'b0;
         sel_num   <= '0;
         sel_valid <= 1'b0;
      end else begin
         sel_oh_q  <= sel_oh_d;
         sel_nmi_q <= sel_nmi_d;
         sel_num   <= num_d;
         sel_valid <= valid_d;
      end
   end

   p_nmi_shown_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pend |-> (sel_num == NMI_NUM && sel_valid));
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_out == '0 && !nmi_pend) |-> (!sel_valid && sel_num == '0));
   p_shown_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_valid && !sel_nmi_q) |-> ((sel_oh_q & pend_out) != '0));
   p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && sel_valid && !sel_nmi_q && (sel_oh_q & pend_set) == '0)
      |=> ((pend_out & $past(sel_oh_q)) == '0));
   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_oh_q));
endmodule

// File: tb/tb_sys_exc_arbiter.sv
`timescale 1ns/1ps
module tb_sys_exc_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  pend_set = '0, pend_clr = '0;
   logic        nmi_set = 1'b0;
   logic [2:0]  fault_en = '0;
   logic [47:0] prio_slots = '0;
   logic        ack = 1'b0;
   logic [5:0]  pend_out;
   logic        nmi_pend;
   logic [3:0]  sel_num;
   logic        sel_valid;

   int tests = 0, fails = 0, cycles = 0;

   always #2.5 clk = ~clk;

   sys_exc_arbiter dut (
      .clk(clk), .rst_n(rst_n), .pend_set(pend_set), .pend_clr(pend_clr),
      .nmi_set(nmi_set), .fault_en(fault_en), .prio_slots(prio_slots),
      .ack(ack), .pend_out(pend_out), .nmi_pend(nmi_pend),
      .sel_num(sel_num), .sel_valid(sel_valid)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
         $finish;
      end
   end

   function automatic int num_of(int i);
      case (i)
         0: return 4;  1: return 5;  2: return 6;
         3: return 11; 4: return 14; default: return 15;
      endcase
   endfunction

   function automatic int expect_num(logic [5:0] p, logic nmi, logic [2:0] en,
                                     logic [47:0] s);
      int best = -1, bp = 8;
      if (nmi) return 2;
      for (int i = 0; i < 6; i++) begin
         int pr = int'(s[8*i+5 +: 3]);
         if (p[i] && (i > 2 || en[i]) && pr < bp) begin
            best = i; bp = pr;
         end
      end
      return (best < 0) ? 0 : num_of(best);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_sel(string req, int exp);
      chk(int'(sel_num) == exp && sel_valid == (exp != 0), req, int'(sel_num), exp);
   endtask

   function automatic logic [47:0] make_slots(int k, int salt);
      logic [47:0] s = '0;
      for (int i = 0; i < 6; i++) begin
         int pr;
         case (k)
            0: pr = 0;
            1: pr = 7 - i;
            2: pr = (3*i + 1) % 8;
            default: pr = (i % 2) ? 2 : 5;
         endcase
         s[8*i+5 +: 3] = 3'(pr);
         s[8*i +: 5]   = 5'((i*7 + salt) % 32);
      end
      return s;
   endfunction

   initial begin
      logic [5:0] mp;
      logic       mn;
      int e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pend_out == 0 && nmi_pend == 0, "R1 pending", int'(pend_out), 0);
      chk_sel("R1 selection", 0);

      // R2 R4 R5 R9 sweep
      for (int k = 0; k < 4; k++)
         for (int en = 0; en < 8; en++)
            for (int p = 0; p < 64; p++) begin
               pend_clr = 6'h3f; pend_set = 6'(p);
               fault_en = 3'(en); prio_slots = make_slots(k, p + en);
               step();
               pend_clr = '0; pend_set = '0;
               chk(pend_out == 6'(p), "R2 set pulse", int'(pend_out), p);
               e = expect_num(6'(p), 1'b0, 3'(en), prio_slots);
               chk_sel((e == 0) ? "R9 none eligible" : "R4 R5 select", e);
            end

      // R3 set and clear together
      pend_clr = 6'h3f; step(); pend_clr = '0;
      pend_set = 6'h08; pend_clr = 6'h08; step();
      pend_set = '0; pend_clr = '0;
      chk(pend_out == 6'h08, "R3 set wins", int'(pend_out), 8);
      pend_clr = 6'h08; step(); pend_clr = '0;
      chk(pend_out == 6'h00, "R3 clear", int'(pend_out), 0);

      // R6 low slot bits have no effect
      fault_en = 3'h7; prio_slots = make_slots(2, 0);
      pend_set = 6'h3f; step(); pend_set = '0;
      e = expect_num(6'h3f, 1'b0, 3'h7, prio_slots);
      for (int salt = 1; salt < 32; salt += 5) begin
         prio_slots = make_slots(2, salt);
         step();
         chk_sel("R6 low bits ignored", e);
      end

      // R10 enable and priority changes show after one edge
      pend_clr = 6'h3f; step(); pend_clr = '0;
      prio_slots = '0; prio_slots[8*5+5 +: 3] = 3'd3; prio_slots[8*1+5 +: 3] = 3'd1;
      fault_en = 3'h0; pend_set = 6'h22; step(); pend_set = '0;
      chk_sel("R10 fault disabled", 15);
      fault_en = 3'h2; step();
      chk_sel("R10 enable change", 5);
      prio_slots[8*1+5 +: 3] = 3'd6; step();
      chk_sel("R10 priority change", 15);

      // R7 non-maskable overrides
      nmi_set = 1'b1; step(); nmi_set = 1'b0;
      chk(nmi_pend == 1'b1, "R7 nmi pending", int'(nmi_pend), 1);
      chk_sel("R7 nmi shown", 2);
      fault_en = 3'h7; prio_slots = '0; step();
      chk_sel("R7 nmi still shown", 2);

      // R8 acknowledge sequence
      prio_slots = make_slots(2, 9);
      pend_set = 6'h3f; step(); pend_set = '0;
      mp = 6'h3f; mn = 1'b1;
      for (int n = 0; n < 7; n++) begin
         e = expect_num(mp, mn, 3'h7, prio_slots);
         chk_sel("R8 ack order", e);
         if (e == 2) mn = 1'b0;
         else for (int i = 0; i < 6; i++) if (num_of(i) == e) mp[i] = 1'b0;
         ack = 1'b1; step(); ack = 1'b0;
         chk(pend_out == mp && nmi_pend == mn, "R8 ack clears",
             int'({nmi_pend, pend_out}), int'({mn, mp}));
      end
      chk_sel("R9 drained", 0);
      ack = 1'b1; step(); ack = 1'b0;
      chk(pend_out == 0 && nmi_pend == 0, "R8 ack without selection",
          int'(pend_out), 0);
      pend_set = 6'h01; step(); pend_set = '0;
      chk_sel("R8 refill", 4);
      ack = 1'b1; pend_set = 6'h01; step(); ack = 1'b0; pend_set = '0;
      chk(pend_out == 6'h01, "R8 set beats ack", int'(pend_out), 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule